// File: doc/BRIEF.md
# GPIO Bank Register Block

This block holds the software-visible control state for one bank of general-purpose pins. The bank is split into four ports of eight pins each. Each port owns a set of byte-wide registers that a simple register bus reaches: pin configuration (GPIO mode), output enable, output data, a synchronized input view, and the enable, type, status and clear registers of a separate interrupt-sensing block. The configuration, output enable and output data registers drive the pads directly. The input view is the pad level after a two-stage synchronizer, and the same synchronized level goes out to the interrupt logic.

Besides the plain address, every writable register answers at a second, masked alias address. In a write to the alias, the upper data byte selects which pins change and the lower byte gives their new levels. A driver can therefore move one pin without a read-modify-write and without a lock shared with other users of the same port. To make a pin an output, software first writes its data bit, then sets its enable bit, then sets its configuration bit. To make it an input, software clears its enable bit and sets its configuration bit.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous reset, every stored register is zero. So `pad_out`, `pad_oe`, `gpio_mode`, `irq_en`, `irq_type`, `irq_clr`, the status write strobes and `bus_rdata` are all 0.
- R2: A plain write (the alias bit clear) to the configuration, output-enable, output-data, interrupt-enable or interrupt-type group of a port replaces that port's 8 bits with `bus_wdata[7:0]`. The new value is visible at the outputs and in later reads right after the write edge. Other ports are unchanged.
- R3: A write with address bit `UPPER_OFS` set (masked alias) updates only the bits whose mask bit `bus_wdata[8+i]` is 1, giving each such bit the value `bus_wdata[i]`. Every bit with mask 0 keeps its old value.
- R4: Address decode. `bus_addr[3:2]` selects the port. `bus_addr[6:4]` selects the group: 0 configuration, 1 output enable, 2 output data, 3 input, 4 interrupt status, 5 interrupt enable, 6 interrupt type, 7 interrupt clear. Pin index is port*8+bit on every 32-bit vector.
- R5: `gpio_mode` equals the configuration bits and `pad_out` equals the output-data bits. `pad_oe` for a pin is 1 only when both its configuration bit and its output-enable bit are 1.
- R6: `pin_level` follows `pad_in` two clock edges later. A read of the input group returns `pin_level` for that port, whatever the pin direction.
- R7: A plain write to the clear group pulses `irq_clr` for that port's pins with `bus_wdata[7:0]` for exactly one cycle. A masked write to the clear group has no effect. Reads of the clear group return 0.
- R8: A read of the status group returns `irq_sta` for that port. A masked write to the status group pulses `irq_sta_wmask` with the mask and `irq_sta_wval` with data AND mask for one cycle. Plain writes to the status or input group change no output.
- R9: `bus_rdata` loads one edge after `bus_rd` is sampled high, with bits above 7 zero. It holds its value on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data; bits 15:8 are the mask at the alias |
| bus_rdata | output | DATA_W | Registered read data |
| pad_in | input | NPORT*PIN_W | Raw pad levels |
| pad_out | output | NPORT*PIN_W | Pad output levels |
| pad_oe | output | NPORT*PIN_W | Pad output enables |
| gpio_mode | output | NPORT*PIN_W | Per-pin GPIO-mode flag for the pin multiplexer |
| pin_level | output | NPORT*PIN_W | Synchronized pad levels for interrupt sensing |
| irq_en | output | NPORT*PIN_W | Interrupt enable bits |
| irq_type | output | NPORT*PIN_W | Interrupt type bits |
| irq_sta | input | NPORT*PIN_W | Interrupt status from the sensing block |
| irq_clr | output | NPORT*PIN_W | One-cycle status clear pulses |
| irq_sta_wmask | output | NPORT*PIN_W | One-cycle mask of a masked status write |
| irq_sta_wval | output | NPORT*PIN_W | One-cycle values of a masked status write |

## Verification
Register writes take effect at the write edge, so the bench checks pad and control outputs at the falling edge that follows. Clear and status strobes are checked at that same falling edge and again one cycle later, when they must be back at zero. Read data is due one edge after the read strobe. The driver queues the expected byte when it issues the read, and a monitor compares it at the next falling edge. Input levels are checked one falling edge after a pad change (still old) and two falling edges after it (new).

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [2:0] {
    GRP_CFG  = 3'd0,
    GRP_OE   = 3'd1,
    GRP_OUT  = 3'd2,
    GRP_IN   = 3'd3,
    GRP_STA  = 3'd4,
    GRP_EN   = 3'd5,
    GRP_TYPE = 3'd6,
    GRP_CLR  = 3'd7
  } grp_e;

  localparam int GRP_W = 3;

  // Keep bits outside the mask, take new bits inside it.
  function automatic logic [7:0] merge_bits(input logic [7:0] old_v,
                                            input logic [7:0] new_v,
                                            input logic [7:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NPORT     = 4,
  parameter int UPPER_OFS = 'h80,
  localparam int PORT_W   = $clog2(NPORT),
  localparam int GRP_LSB  = 2 + PORT_W
) (
  input  logic [ADDR_W-1:0] bus_addr,
  output grp_e              dec_grp,
  output logic [PORT_W-1:0] dec_port,
  output logic              dec_masked
);

  localparam logic [ADDR_W-1:0] ALIAS_BIT = ADDR_W'(UPPER_OFS);

  assign dec_port   = bus_addr[2 +: PORT_W];
  assign dec_grp    = grp_e'(bus_addr[GRP_LSB +: GRP_W]);
  assign dec_masked = |(bus_addr & ALIAS_BIT);

  logic unused_addr;
  assign unused_addr = ^bus_addr;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_hit,
  input  logic               masked,
  input  grp_e               grp,
  input  logic [2*PIN_W-1:0] wdata,
  output logic [PIN_W-1:0]   cfg_q,
  output logic [PIN_W-1:0]   oe_q,
  output logic [PIN_W-1:0]   out_q,
  output logic [PIN_W-1:0]   en_q,
  output logic [PIN_W-1:0]   type_q,
  output logic [PIN_W-1:0]   clr_q,
  output logic [PIN_W-1:0]   sta_wmask_q,
  output logic [PIN_W-1:0]   sta_wval_q
);

  logic [PIN_W-1:0] wr_val, wr_mask;

  assign wr_val  = wdata[PIN_W-1:0];
  assign wr_mask = masked ? wdata[2*PIN_W-1:PIN_W] : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= '0;
      oe_q        <= '0;
      out_q       <= '0;
      en_q        <= '0;
      type_q      <= '0;
      clr_q       <= '0;
      sta_wmask_q <= '0;
      sta_wval_q  <= '0;
    end else begin
      clr_q       <= '0;
      sta_wmask_q <= '0;
      sta_wval_q  <= '0;
      if (wr_hit) begin
        case (grp)
          GRP_CFG:  cfg_q  <= merge_bits(cfg_q,  wr_val, wr_mask);
          GRP_OE:   oe_q   <= merge_bits(oe_q,   wr_val, wr_mask);
          GRP_OUT:  out_q  <= merge_bits(out_q,  wr_val, wr_mask);
          GRP_EN:   en_q   <= merge_bits(en_q,   wr_val, wr_mask);
          GRP_TYPE: type_q <= merge_bits(type_q, wr_val, wr_mask);
          GRP_CLR:  if (!masked) clr_q <= wr_val;
          GRP_STA: if (masked) begin
            sta_wmask_q <= wr_mask;
            sta_wval_q  <= wr_val & wr_mask;
          end
          default: ;
        endcase
      end
    end
  end

  // R3: unmasked bits of the output-data register survive a masked write
  p_mask_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && masked && grp == GRP_OUT) |=>
      (((out_q ^ $past(out_q)) & ~$past(wdata[2*PIN_W-1:PIN_W])) == '0));

  // R3: same for the configuration register
  p_mask_keep_cfg_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && masked && grp == GRP_CFG) |=>
      (((cfg_q ^ $past(cfg_q)) & ~$past(wdata[2*PIN_W-1:PIN_W])) == '0));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NPORT     = 4,
  parameter int PIN_W     = 8,
  parameter int UPPER_OFS = 'h80,
  localparam int NPIN     = NPORT * PIN_W,
  localparam int PORT_W   = $clog2(NPORT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   gpio_mode,
  output logic [NPIN-1:0]   pin_level,
  output logic [NPIN-1:0]   irq_en,
  output logic [NPIN-1:0]   irq_type,
  input  logic [NPIN-1:0]   irq_sta,
  output logic [NPIN-1:0]   irq_clr,
  output logic [NPIN-1:0]   irq_sta_wmask,
  output logic [NPIN-1:0]   irq_sta_wval
);

  grp_e              dec_grp;
  logic [PORT_W-1:0] dec_port;
  logic              dec_masked;

  gpio_bus_decode #(
    .ADDR_W(ADDR_W), .NPORT(NPORT), .UPPER_OFS(UPPER_OFS)
  ) u_decode (
    .bus_addr  (bus_addr),
    .dec_grp   (dec_grp),
    .dec_port  (dec_port),
    .dec_masked(dec_masked)
  );

  gpio_in_sync #(.WIDTH(NPIN)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_in(pad_in),
    .sync_out(pin_level)
  );

  logic [PIN_W-1:0] cfg_a [NPORT];
  logic [PIN_W-1:0] oe_a  [NPORT];
  logic [PIN_W-1:0] out_a [NPORT];
  logic [PIN_W-1:0] en_a  [NPORT];
  logic [PIN_W-1:0] ty_a  [NPORT];
  logic [PIN_W-1:0] in_a  [NPORT];
  logic [PIN_W-1:0] sta_a [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic port_hit;
    assign port_hit = bus_wr && (dec_port == PORT_W'(p));

    gpio_port_regs #(.PIN_W(PIN_W)) u_regs (
      .clk        (clk),
      .rst        (rst),
      .wr_hit     (port_hit),
      .masked     (dec_masked),
      .grp        (dec_grp),
      .wdata      (bus_wdata[2*PIN_W-1:0]),
      .cfg_q      (cfg_a[p]),
      .oe_q       (oe_a[p]),
      .out_q      (out_a[p]),
      .en_q       (en_a[p]),
      .type_q     (ty_a[p]),
      .clr_q      (irq_clr[p*PIN_W +: PIN_W]),
      .sta_wmask_q(irq_sta_wmask[p*PIN_W +: PIN_W]),
      .sta_wval_q (irq_sta_wval[p*PIN_W +: PIN_W])
    );

    assign gpio_mode[p*PIN_W +: PIN_W] = cfg_a[p];
    assign pad_out[p*PIN_W +: PIN_W]   = out_a[p];
    assign pad_oe[p*PIN_W +: PIN_W]    = cfg_a[p] & oe_a[p];
    assign irq_en[p*PIN_W +: PIN_W]    = en_a[p];
    assign irq_type[p*PIN_W +: PIN_W]  = ty_a[p];
    assign in_a[p]  = pin_level[p*PIN_W +: PIN_W];
    assign sta_a[p] = irq_sta[p*PIN_W +: PIN_W];
  end

  logic [PIN_W-1:0] rd_byte;

  always_comb begin
    rd_byte = '0;
    case (dec_grp)
      GRP_CFG:  rd_byte = cfg_a[dec_port];
      GRP_OE:   rd_byte = oe_a[dec_port];
      GRP_OUT:  rd_byte = out_a[dec_port];
      GRP_IN:   rd_byte = in_a[dec_port];
      GRP_STA:  rd_byte = sta_a[dec_port];
      GRP_EN:   rd_byte = en_a[dec_port];
      GRP_TYPE: rd_byte = ty_a[dec_port];
      default:  rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= {{(DATA_W-PIN_W){1'b0}}, rd_byte};
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DATA_W-1:2*PIN_W];

  // R5: pad drivers only move in response to a register write
  p_oe_by_write_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(pad_oe) |-> $past(bus_wr));

  // R9: read data holds when no read is issued
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R7: a clear pulse always follows a bus write
  p_clr_after_write_r7: assert property (@(posedge clk) disable iff (rst)
    (|irq_clr) |-> $past(bus_wr));

  // R8: status strobes follow a bus write and values stay inside the mask
  p_sta_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (|irq_sta_wmask) |-> ($past(bus_wr) && ((irq_sta_wval & ~irq_sta_wmask) == '0)));

endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;

  localparam int NPIN = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NPIN-1:0] pad_in = '0, irq_sta = '0;
  logic [NPIN-1:0] pad_out, pad_oe, gpio_mode, pin_level;
  logic [NPIN-1:0] irq_en, irq_type, irq_clr, irq_sta_wmask, irq_sta_wval;

  always #10 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .gpio_mode(gpio_mode), .pin_level(pin_level), .irq_en(irq_en),
    .irq_type(irq_type), .irq_sta(irq_sta), .irq_clr(irq_clr),
    .irq_sta_wmask(irq_sta_wmask), .irq_sta_wval(irq_sta_wval)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [8][4];

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [11:0] adr(int g, int p, bit m);
    return 12'((m ? 'h80 : 0) | (g << 4) | (p << 2));
  endfunction

  function automatic logic [31:0] vec(int g);
    return {mdl[g][3], mdl[g][2], mdl[g][1], mdl[g][0]};
  endfunction

  // driver: write, updates the model of stored groups
  task automatic wr(int g, int p, bit m, logic [15:0] d);
    logic [7:0] mk;
    mk = m ? d[15:8] : 8'hFF;
    bus_wr = 1'b1; bus_addr = adr(g, p, m); bus_wdata = {16'h0, d};
    if (g == 0 || g == 1 || g == 2 || g == 5 || g == 6)
      mdl[g][p] = (mdl[g][p] & ~mk) | (d[7:0] & mk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: read, pushes expected byte to the scoreboard
  task automatic rd(int g, int p, logic [7:0] e, string tag);
    bus_rd = 1'b1; bus_addr = adr(g, p, 1'b0);
    exp_q.push_back({24'h0, e});
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected read data", bus_rdata, 32'hx);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    finish_run();
  end

  initial begin
    for (int g = 0; g < 8; g++)
      for (int p = 0; p < 4; p++) mdl[g][p] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 gpio_mode", gpio_mode, 32'h0);
    check("R1 irq_en", irq_en, 32'h0);
    check("R1 irq_clr", irq_clr, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rd(0, 0, 8'h00, "R1 cfg read");

    // R2 / R4 plain writes, different ports and groups
    wr(0, 0, 0, 16'h00A5);
    wr(1, 0, 0, 16'h000F);
    wr(2, 0, 0, 16'h003C);
    wr(0, 2, 0, 16'hFFFF);
    wr(5, 1, 0, 16'h0081);
    wr(6, 3, 0, 16'h0042);
    check("R2 irq_en vector", irq_en, vec(5));
    check("R4 irq_type placement", irq_type, 32'h4200_0000);
    check("R5 gpio_mode", gpio_mode, vec(0));
    check("R5 pad_out", pad_out, vec(2));
    check("R5 pad_oe cfg&oe", pad_oe, vec(0) & vec(1));
    rd(0, 0, 8'hA5, "R2 cfg p0");
    rd(1, 0, 8'h0F, "R2 oe p0");
    rd(2, 0, 8'h3C, "R2 out p0");
    rd(0, 2, 8'hFF, "R4 cfg p2");
    rd(5, 1, 8'h81, "R4 en p1");
    rd(6, 3, 8'h42, "R4 type p3");
    rd(0, 1, 8'h00, "R2 untouched port");

    // R3 masked writes
    wr(2, 0, 1, 16'hF0A0);
    rd(2, 0, 8'hAC, "R3 masked out p0");
    check("R3 pad_out", pad_out, vec(2));
    wr(0, 2, 1, 16'h0F00);
    check("R3 masked cfg", gpio_mode, vec(0));
    rd(0, 2, 8'hF0, "R3 masked cfg p2");
    wr(5, 1, 1, 16'h0000);
    rd(5, 1, 8'h81, "R3 zero mask keeps all");

    // output sequence on port 3 bit 5: data, enable, config
    wr(2, 3, 1, 16'h2020);
    wr(1, 3, 1, 16'h2020);
    check("R5 oe waits for cfg", pad_oe[29], 1'b0);
    wr(0, 3, 1, 16'h2020);
    check("R5 pin 29 driven", pad_oe, vec(0) & vec(1));
    check("R5 pin 29 level", pad_out[29], 1'b1);

    // R6 input synchronizer
    pad_in = 32'h1234_5678;
    @(negedge clk);
    check("R6 one edge still old", pin_level, 32'h0);
    @(negedge clk);
    check("R6 two edges new", pin_level, 32'h1234_5678);
    rd(3, 1, 8'h56, "R6 input p1");
    rd(3, 0, 8'h78, "R6 input of output-mode port");

    // R8 status read and strobes
    irq_sta = 32'hDEAD_BEEF;
    rd(4, 3, 8'hDE, "R8 status p3");
    wr(4, 1, 1, 16'h0CFF);
    check("R8 sta wmask", irq_sta_wmask, 32'h0000_0C00);
    check("R8 sta wval", irq_sta_wval, 32'h0000_0C00);
    @(negedge clk);
    check("R8 strobe one cycle", irq_sta_wmask, 32'h0);
    wr(4, 1, 0, 16'h00FF);
    check("R8 plain status write", irq_sta_wmask | irq_clr, 32'h0);
    wr(3, 1, 0, 16'h0000);
    rd(3, 1, 8'h56, "R8 plain input write ignored");

    // R7 clear pulses
    wr(7, 2, 0, 16'h0011);
    check("R7 clr pulse", irq_clr, 32'h0011_0000);
    @(negedge clk);
    check("R7 clr one cycle", irq_clr, 32'h0);
    wr(7, 2, 1, 16'hFFFF);
    check("R7 masked clear ignored", irq_clr, 32'h0);
    rd(7, 2, 8'h00, "R7 clear reads zero");

    // R9 hold
    repeat (2) @(negedge clk);
    check("R9 rdata holds", bus_rdata, 32'h0);
    check("R9 scoreboard drained", exp_q.size(), 0);

    finish_run();
  end

endmodule